// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block drives the system reset of a chip from three causes. The first is a power-on event, signalled by an asynchronous active-low power-on input. The second is a digital supply-good flag that an analog comparator outside the block produces. The third is a watchdog that expires when the active-low kick input is not pulsed often enough. All three causes feed one reset stretcher. That stretcher asserts reset and releases it only after a fixed number of timebase ticks have been counted with the supply good. The block presents the reset in both polarities.

All durations are counted in ticks of a timebase input, one tick per millisecond in a real system, and are set by parameters. The watchdog interval comes from a 2-bit selection register. The power-on input does not clear this register; only a write changes it. One code turns the watchdog off, and that code is the default. The kick input is synchronised. A restart counts only when a low pulse lasts at least a minimum number of clocks. The block has no data stream, so every pin is a plain control or status pin.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `por_n` is low, `rst_hi` is 1. After `por_n` rises with the supply good, `rst_hi` stays 1 through HOLD_TICKS-1 ticks and drops on the clock edge that samples the HOLD_TICKS-th tick.
- R2: `rst_lo` is always the inverse of `rst_hi`.
- R3: Within three clocks of `supply_ok` going low, `rst_hi` is 1, and it stays 1 for as long as the supply is low. When the supply recovers, the hold count starts again from zero, including when the supply dipped part way through a hold, so a full HOLD_TICKS ticks are needed before release.
- R4: Selection code 2'b10 gives a watchdog interval of WD_SHORT_TICKS ticks, 2'b01 gives WD_MID_TICKS and 2'b00 gives WD_LONG_TICKS. If no restart arrives, `rst_hi` rises on the edge that samples the interval-th tick after the count began.
- R5: Selection code 2'b11 disables the watchdog, so no number of ticks causes a reset. The selection register powers up holding SEL_DEFAULT, which is 2'b11 by default.
- R6: A restart occurs when `kick_n` falls and, after synchronisation, stays low for at least KICK_MIN_CLKS clocks. A restart clears the watchdog count. A low pulse shorter than KICK_MIN_CLKS clocks has no effect on the count.
- R7: After a watchdog expiry, `rst_hi` stays 1 through HOLD_TICKS-1 ticks and releases on the HOLD_TICKS-th tick.
- R8: The watchdog count is held at zero while reset is asserted. After a release, a full interval of ticks is needed before the next expiry.
- R9: The selection register changes only on a clock edge with `sel_wr` high. A pulse on `por_n` does not clear it. A write also clears the watchdog count.
- R10: If a restart and the tick that would complete the interval fall in the same clock, the restart wins: no reset occurs and the count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| tick_ms | input | 1 | Timebase tick, one clock wide |
| supply_ok | input | 1 | Supply-good flag from the comparator, asynchronous |
| kick_n | input | 1 | Watchdog kick / select, active low, asynchronous |
| sel_wr | input | 1 | Write strobe for the interval selection |
| sel_in | input | 2 | Interval selection: 00 long, 01 mid, 10 short, 11 off |
| rst_hi | output | 1 | System reset, active high |
| rst_lo | output | 1 | System reset, active low |

## Verification
The coincidence that matters is a qualified kick landing in the same clock as the tick that would complete the watchdog interval. The bench provokes it by filling the count to one tick short of the interval. It then drops the kick line and raises the tick exactly in the clock where the synchronised low pulse reaches its minimum width. The case passes if reset stays deasserted and a full fresh interval is afterwards needed to expire. A second overlap, a supply dip partway through a hold, is judged by requiring a complete hold count after recovery.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;

  // Watchdog interval selection codes
  typedef enum logic [1:0] {
    SEL_LONG  = 2'b00,
    SEL_MID   = 2'b01,
    SEL_SHORT = 2'b10,
    SEL_OFF   = 2'b11
  } wd_sel_e;

  // Reset stretcher phase
  typedef enum logic {
    PH_HOLD = 1'b0,
    PH_RUN  = 1'b1
  } rst_phase_e;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d_in,
  output logic q_out
);

  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) pipe <= IDLE;
        else         pipe <= d_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) pipe <= {STAGES{IDLE}};
        else         pipe <= {pipe[STAGES-2:0], d_in};
      end
    end
  endgenerate

  assign q_out = pipe[STAGES-1];

endmodule

// File: rtl/sup_kick_qual.sv
module sup_kick_qual #(
  parameter int MIN_CLKS = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic kick_s,     // synchronised, active low
  output logic restart_o
);

  localparam int LW = $clog2(MIN_CLKS + 1);

  // Clocks spent low since the falling edge, saturating at MIN_CLKS.
  // A zero count while low marks the falling-edge cycle itself.
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      low_cnt <= '0;
    end else if (kick_s) begin
      low_cnt <= '0;
    end else if (low_cnt != LW'(MIN_CLKS)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign restart_o = !kick_s && (low_cnt == LW'(MIN_CLKS - 1));

  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!arst_n)
    restart_o |=> !restart_o); // R6

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
  import sup_rst_pkg::*;
#(
  parameter int         SHORT_TICKS = 200,
  parameter int         MID_TICKS   = 600,
  parameter int         LONG_TICKS  = 1400,
  parameter logic [1:0] SEL_DEFAULT = 2'b11
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       tick,
  input  logic       hold_rst,
  input  logic       restart,
  input  logic       sel_wr,
  input  logic [1:0] sel_in,
  output logic       expire_o
);

  localparam int MAX_A  = (SHORT_TICKS > MID_TICKS) ? SHORT_TICKS : MID_TICKS;
  localparam int MAX_T  = (MAX_A > LONG_TICKS) ? MAX_A : LONG_TICKS;
  localparam int CW     = $clog2(MAX_T + 1);

  // Retained selection: loaded once at start-up, then only by a write.
  wd_sel_e sel_q = wd_sel_e'(SEL_DEFAULT);

  always_ff @(posedge clk) begin
    if (sel_wr) sel_q <= wd_sel_e'(sel_in);
  end

  logic [CW-1:0] limit;
  logic          en;

  always_comb begin
    unique case (sel_q)
      SEL_SHORT: limit = CW'(SHORT_TICKS);
      SEL_MID:   limit = CW'(MID_TICKS);
      SEL_LONG:  limit = CW'(LONG_TICKS);
      default:   limit = '0;
    endcase
  end

  assign en = (sel_q != SEL_OFF);

  logic [CW-1:0] cnt;
  logic          clear;
  logic          last;

  assign clear = hold_rst || restart || sel_wr || !en;
  assign last  = (cnt == limit - CW'(1));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  assign expire_o = !clear && tick && last;

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!arst_n)
    en |-> (cnt < limit)); // R4

  AST_CNT_ZERO_IN_RST: assert property (@(posedge clk) disable iff (!arst_n)
    hold_rst |=> (cnt == '0)); // R8

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!arst_n)
    restart |=> (cnt == '0)); // R6

endmodule

// File: rtl/sup_rst_hold.sv
module sup_rst_hold
  import sup_rst_pkg::*;
#(
  parameter int HOLD_TICKS = 200
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick,
  input  logic supply_ok,
  input  logic wd_expire,
  output logic rst_o
);

  localparam int HW = $clog2(HOLD_TICKS + 1);

  rst_phase_e    phase;
  logic [HW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase    <= PH_HOLD;
      hold_cnt <= '0;
    end else begin
      unique case (phase)
        PH_RUN: begin
          if (!supply_ok || wd_expire) begin
            phase    <= PH_HOLD;
            hold_cnt <= '0;
          end
        end
        default: begin
          if (!supply_ok) begin
            hold_cnt <= '0;
          end else if (tick) begin
            if (hold_cnt == HW'(HOLD_TICKS - 1)) begin
              phase    <= PH_RUN;
              hold_cnt <= '0;
            end else begin
              hold_cnt <= hold_cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign rst_o = (phase == PH_HOLD);

  AST_LOW_SUPPLY_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
    !supply_ok |=> rst_o); // R3

  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rst_o) |-> $past(tick) && $past(supply_ok)); // R1

  AST_EXPIRY_ASSERTS: assert property (@(posedge clk) disable iff (!arst_n)
    wd_expire |=> rst_o); // R7

  AST_HOLD_IN_RANGE: assert property (@(posedge clk) disable iff (!arst_n)
    hold_cnt < HW'(HOLD_TICKS)); // R1

endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
  parameter int         HOLD_TICKS     = 200,
  parameter int         WD_SHORT_TICKS = 200,
  parameter int         WD_MID_TICKS   = 600,
  parameter int         WD_LONG_TICKS  = 1400,
  parameter int         KICK_MIN_CLKS  = 4,
  parameter int         SYNC_STAGES    = 2,
  parameter logic [1:0] SEL_DEFAULT    = 2'b11
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       tick_ms,
  input  logic       supply_ok,
  input  logic       kick_n,
  input  logic       sel_wr,
  input  logic [1:0] sel_in,
  output logic       rst_hi,
  output logic       rst_lo
);

  logic sup_s;
  logic kick_s;
  logic kick_restart;
  logic wd_expire;
  logic rst_q;

  // Supply flag treated as bad until proven good after power-on.
  sup_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_sync_sup (
    .clk    (clk),
    .arst_n (por_n),
    .d_in   (supply_ok),
    .q_out  (sup_s)
  );

  // Kick line idles high.
  sup_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync_kick (
    .clk    (clk),
    .arst_n (por_n),
    .d_in   (kick_n),
    .q_out  (kick_s)
  );

  sup_kick_qual #(.MIN_CLKS(KICK_MIN_CLKS)) u_kick (
    .clk       (clk),
    .arst_n    (por_n),
    .kick_s    (kick_s),
    .restart_o (kick_restart)
  );

  sup_wdog #(
    .SHORT_TICKS (WD_SHORT_TICKS),
    .MID_TICKS   (WD_MID_TICKS),
    .LONG_TICKS  (WD_LONG_TICKS),
    .SEL_DEFAULT (SEL_DEFAULT)
  ) u_wdog (
    .clk      (clk),
    .arst_n   (por_n),
    .tick     (tick_ms),
    .hold_rst (rst_q),
    .restart  (kick_restart),
    .sel_wr   (sel_wr),
    .sel_in   (sel_in),
    .expire_o (wd_expire)
  );

  sup_rst_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk       (clk),
    .arst_n    (por_n),
    .tick      (tick_ms),
    .supply_ok (sup_s),
    .wd_expire (wd_expire),
    .rst_o     (rst_q)
  );

  assign rst_hi = rst_q;
  assign rst_lo = ~rst_q;

  AST_KICK_BEATS_EXPIRY: assert property (@(posedge clk) disable iff (!por_n)
    kick_restart |-> !wd_expire); // R10

  AST_NO_EXPIRY_IN_RST: assert property (@(posedge clk) disable iff (!por_n)
    rst_q |-> !wd_expire); // R8

endmodule

// File: tb/sup_reset_ctrl_test.sv
module sup_reset_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD  = 5;
  localparam int T_SH  = 3;
  localparam int T_MD  = 6;
  localparam int T_LG  = 9;
  localparam int KMIN  = 4;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       tick_ms = 1'b0;
  logic       supply_ok = 1'b1;
  logic       kick_n = 1'b1;
  logic       sel_wr = 1'b0;
  logic [1:0] sel_in = 2'b00;
  logic       rst_hi;
  logic       rst_lo;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sup_reset_ctrl #(
    .HOLD_TICKS     (HOLD),
    .WD_SHORT_TICKS (T_SH),
    .WD_MID_TICKS   (T_MD),
    .WD_LONG_TICKS  (T_LG),
    .KICK_MIN_CLKS  (KMIN),
    .SYNC_STAGES    (2),
    .SEL_DEFAULT    (2'b11)
  ) uut (
    .clk       (clk),
    .por_n     (por_n),
    .tick_ms   (tick_ms),
    .supply_ok (supply_ok),
    .kick_n    (kick_n),
    .sel_wr    (sel_wr),
    .sel_in    (sel_in),
    .rst_hi    (rst_hi),
    .rst_lo    (rst_lo)
  );

  // Vector: {selection, ticks without kick, expected rst_hi}
  localparam logic [10:0] VECS [0:6] = '{
    {2'b10, 8'd2,  1'b0},
    {2'b10, 8'd3,  1'b1},
    {2'b01, 8'd5,  1'b0},
    {2'b01, 8'd6,  1'b1},
    {2'b11, 8'd20, 1'b0},
    {2'b00, 8'd8,  1'b0},
    {2'b00, 8'd9,  1'b1}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_ms = 1'b1;
      @(negedge clk) tick_ms = 1'b0;
    end
  endtask

  task automatic write_sel(input logic [1:0] v);
    @(negedge clk) begin sel_wr = 1'b1; sel_in = v; end
    @(negedge clk) sel_wr = 1'b0;
  endtask

  task automatic kick_pulse(input int width);
    @(negedge clk) kick_n = 1'b0;
    idle(width);
    kick_n = 1'b1;
    idle(4);
  endtask

  // Release from a held reset; checks the hold length on the way.
  task automatic recover(input string tag);
    ticks(HOLD - 1);
    chk({tag, " still held"}, rst_hi, 1'b1);
    ticks(1);
    chk({tag, " released"}, rst_hi, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 / R2: reset state under power-on
    idle(3);
    chk("R1 por low rst_hi", rst_hi, 1'b1);
    chk("R2 por low rst_lo", rst_lo, 1'b0);
    @(negedge clk) por_n = 1'b1;
    idle(4);
    ticks(HOLD - 1);
    chk("R1 hold before last tick", rst_hi, 1'b1);
    ticks(1);
    chk("R1 release on last tick", rst_hi, 1'b0);
    chk("R2 rst_lo after release", rst_lo, 1'b1);

    // R5: default selection is off
    ticks(20);
    chk("R5 default code off", rst_hi, 1'b0);

    // R4 / R5 / R7: table of interval codes
    for (int v = 0; v < 7; v++) begin
      write_sel(VECS[v][10:9]);
      ticks(int'(VECS[v][8:1]));
      chk($sformatf("R4 vec %0d", v), rst_hi, VECS[v][0]);
      if (VECS[v][0]) recover($sformatf("R7 vec %0d", v));
    end

    // R3: supply low forces and holds reset
    write_sel(2'b10);
    @(negedge clk) supply_ok = 1'b0;
    idle(3);
    chk("R3 supply low asserts", rst_hi, 1'b1);
    ticks(10);
    chk("R3 held while supply low", rst_hi, 1'b1);
    @(negedge clk) supply_ok = 1'b1;
    idle(4);
    ticks(3);
    @(negedge clk) supply_ok = 1'b0;
    idle(4);
    @(negedge clk) supply_ok = 1'b1;
    idle(4);
    recover("R3 dip mid-hold");

    // R8: count starts from zero after release
    ticks(T_SH - 1);
    chk("R8 fresh interval not done", rst_hi, 1'b0);
    ticks(1);
    chk("R8 fresh interval expires", rst_hi, 1'b1);
    recover("R8");

    // R6: qualified kick restarts
    write_sel(2'b10);
    ticks(T_SH - 1);
    kick_pulse(KMIN + 2);
    ticks(T_SH - 1);
    chk("R6 long kick restarted", rst_hi, 1'b0);
    ticks(1);
    chk("R6 expiry after restart", rst_hi, 1'b1);
    recover("R6");

    // R6: short kick ignored
    write_sel(2'b10);
    ticks(T_SH - 1);
    kick_pulse(KMIN - 2);
    ticks(1);
    chk("R6 short kick ignored", rst_hi, 1'b1);
    recover("R6 short");

    // R9: selection kept across power-on, needs a write strobe
    write_sel(2'b01);
    @(negedge clk) sel_in = 2'b10;
    @(negedge clk) por_n = 1'b0;
    idle(3);
    chk("R9 por asserts", rst_hi, 1'b1);
    @(negedge clk) por_n = 1'b1;
    idle(4);
    recover("R9 por");
    ticks(T_MD - 1);
    chk("R9 kept code mid not yet", rst_hi, 1'b0);
    ticks(1);
    chk("R9 kept code mid expires", rst_hi, 1'b1);
    recover("R9");

    // R10: restart and final tick in the same clock
    write_sel(2'b10);
    ticks(T_SH - 1);
    @(negedge clk) kick_n = 1'b0;
    repeat (KMIN + 1) @(negedge clk);
    tick_ms = 1'b1;
    @(negedge clk) tick_ms = 1'b0;
    chk("R10 restart beats expiry", rst_hi, 1'b0);
    @(negedge clk) kick_n = 1'b1;
    idle(4);
    ticks(T_SH - 1);
    chk("R10 count restarted", rst_hi, 1'b0);
    ticks(1);
    chk("R10 later expiry", rst_hi, 1'b1);
    chk("R2 rst_lo during reset", rst_lo, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule